// File: doc/BRIEF.md
# Split Lookup-Table Logic Cell

This block is one configurable logic cell. It has a 32-entry, one-bit truth table, five external inputs and two flip-flops whose outputs can feed back as table address bits. Address selectors pick each table address bit from seven candidates: the five external inputs and the two flip-flop outputs. A mode field sets how the table is used. It can be one five-variable function, two separate four-variable functions (one on each half), or two halves merged through a 2-to-1 multiplexer whose select is a further variable. This last mode covers some six- and seven-variable functions.

All configuration is one serial shift chain. The chain holds the table contents, the mode, the address selectors and the data source of each flip-flop, and it is loaded one bit per enabled clock. A done flag rises once the full chain length has been shifted in. Until then, every output is held low and both flip-flops stay cleared. The outputs F and G are combinational: a path from a data input to the outputs goes through one selector and one table read, whichever function is programmed. Each flip-flop captures F or G on every clock after configuration is complete.

Top module: `lutcell_top`

## Requirements
- R1: Until `cfg_done` is 1, `f_out`, `g_out`, `qx_out` and `qy_out` are all 0, whatever `ext_in` is.
- R2: `cfg_done` is 0 after reset. It becomes 1 right after the 63rd clock edge at which `cfg_en` is 1; edges with `cfg_en` low are not counted. Once set, it stays set until reset.
- R3: Each enabled edge shifts `cfg_din` into chain bit 0 and moves the chain up one place, so the first bit sent ends at bit 62. The layout is: table entry n at bit n (bits 31:0); mode at bits 33:32; selector S_k at bits 34+3k..36+3k for k = 0..4; selector T_k at bits 49+3k..51+3k for k = 0..3; flip-flop X source at bit 61; flip-flop Y source at bit 62.
- R4: In mode 0, F and G both equal table entry {S4,S3,S2,S1,S0}, with S4 as the most significant address bit.
- R5: In mode 1, F is entry {0,S3..S0} and G is entry {1,T3..T0}.
- R6: In mode 2, F and G both equal S4 ? entry {1,T3..T0} : entry {0,S3..S0}.
- R7: Selector codes: 0 to 4 pick `ext_in[code]`, 5 picks flip-flop X, 6 picks flip-flop Y, and 7 gives a constant 0. Selectors S0, S1, T0 and T1 may only pick external inputs; codes 5 and 6 there give 0.
- R8: After `cfg_done` is 1, each clock edge loads flip-flop X with G if its source bit is 1 and with F otherwise. Flip-flop Y is loaded the same way from its own source bit. The new values act as address candidates from that edge on.
- R9: An active-low `rst_n` clears both flip-flops, the chain and the done flag immediately.
- R10: Mode 3 behaves exactly like mode 0.
- R11: F and G follow a change of `ext_in` within the same cycle, with no register in the path.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift one configuration bit on this edge |
| cfg_din | input | 1 | Serial configuration bit |
| ext_in | input | 5 | External logic inputs (candidates 0 to 4) |
| f_out | output | 1 | Function output F |
| g_out | output | 1 | Function output G |
| qx_out | output | 1 | Flip-flop X output |
| qy_out | output | 1 | Flip-flop Y output |
| cfg_done | output | 1 | Configuration complete |

## Verification
Two events can fall on the same clock edge: the final configuration shift and a flip-flop capture. The bench loads each configuration with no idle cycle after the last bit and starts logic stimulus at once. It then checks that the flip-flops are still 0 in the first cycle after `cfg_done` rises, and that they capture only on the following edge. A second case is a flip-flop that feeds back into the address in the same cycle it changes. The bench handles this by keeping its own flip-flop model, updated at each edge from the F and G values it expected, and by comparing both outputs against that model every cycle.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  typedef enum logic [1:0] {
    MODE_WHOLE = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_MUXED = 2'd2,
    MODE_ALT   = 2'd3
  } cell_mode_e;
endpackage

// File: rtl/lutcell_cfg_chain.sv
module lutcell_cfg_chain #(
  parameter int LEN = 63
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_din,
  output logic [LEN-1:0] image,
  output logic           done
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] fill_cnt;
  logic             at_full;

  assign at_full = (fill_cnt == CNT_W'(LEN));
  assign done    = at_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image    <= '0;
      fill_cnt <= '0;
    end else if (shift_en) begin
      image <= {image[LEN-2:0], shift_din};
      if (!at_full) fill_cnt <= fill_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lutcell_lut_core.sv
module lutcell_lut_core
  import lutcell_pkg::*;
#(
  parameter int EXT_N  = 5,
  parameter int LUT_AW = 5,
  parameter int SEL_W  = 3,
  parameter int PINNED = 2
) (
  input  logic [(1<<LUT_AW)-1:0]      table_bits,
  input  cell_mode_e                  mode,
  input  logic [LUT_AW*SEL_W-1:0]     s_sel,
  input  logic [(LUT_AW-1)*SEL_W-1:0] t_sel,
  input  logic [EXT_N-1:0]            ext,
  input  logic                        qa,
  input  logic                        qb,
  output logic                        f_raw,
  output logic                        g_raw,
  output logic                        whole_w
);
  localparam int HALF_AW = LUT_AW - 1;

  function automatic logic pick(input logic [SEL_W-1:0] sel, input logic ext_only,
                                input logic [EXT_N-1:0] e, input logic a, input logic b);
    if (int'(sel) < EXT_N)       return e[sel];
    else if (ext_only)           return 1'b0;
    else if (int'(sel) == EXT_N) return a;
    else if (int'(sel) == EXT_N + 1) return b;
    else                         return 1'b0;
  endfunction

  logic [LUT_AW-1:0]  s_addr;
  logic [HALF_AW-1:0] t_addr;

  for (genvar k = 0; k < LUT_AW; k++) begin : g_s
    assign s_addr[k] = pick(s_sel[k*SEL_W +: SEL_W], (k < PINNED), ext, qa, qb);
  end
  for (genvar k = 0; k < HALF_AW; k++) begin : g_t
    assign t_addr[k] = pick(t_sel[k*SEL_W +: SEL_W], (k < PINNED), ext, qa, qb);
  end

  logic whole_v, low_v, high_v, merged_v;
  assign whole_v  = table_bits[s_addr];
  assign low_v    = table_bits[{1'b0, s_addr[HALF_AW-1:0]}];
  assign high_v   = table_bits[{1'b1, t_addr}];
  assign merged_v = s_addr[LUT_AW-1] ? high_v : low_v;

  assign whole_w = (mode == MODE_WHOLE) || (mode == MODE_ALT);

  always_comb begin
    unique case (mode)
      MODE_SPLIT: begin f_raw = low_v;    g_raw = high_v;   end
      MODE_MUXED: begin f_raw = merged_v; g_raw = merged_v; end
      default:    begin f_raw = whole_v;  g_raw = whole_v;  end
    endcase
  end
endmodule

// File: rtl/lutcell_ff_pair.sv
module lutcell_ff_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic f_in,
  input  logic g_in,
  input  logic x_from_g,
  input  logic y_from_g,
  output logic qx,
  output logic qy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else if (run) begin
      qx <= x_from_g ? g_in : f_in;
      qy <= y_from_g ? g_in : f_in;
    end
  end
endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
#(
  parameter int EXT_N  = 5,
  parameter int LUT_AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [EXT_N-1:0] ext_in,
  output logic             f_out,
  output logic             g_out,
  output logic             qx_out,
  output logic             qy_out,
  output logic             cfg_done
);
  localparam int SEL_W    = $clog2(EXT_N + 3);
  localparam int LUT_N    = 1 << LUT_AW;
  localparam int HALF_AW  = LUT_AW - 1;
  localparam int MODE_LSB = LUT_N;
  localparam int SSEL_LSB = LUT_N + 2;
  localparam int TSEL_LSB = SSEL_LSB + LUT_AW * SEL_W;
  localparam int FX_BIT   = TSEL_LSB + HALF_AW * SEL_W;
  localparam int FY_BIT   = FX_BIT + 1;
  localparam int CFG_LEN  = FY_BIT + 1;

  logic [CFG_LEN-1:0] image;
  logic               done_w;
  logic               f_raw, g_raw, whole_w;
  logic               qx_w, qy_w;
  logic               fx_src_w, fy_src_w;
  cell_mode_e         mode_w;

  lutcell_cfg_chain #(.LEN(CFG_LEN)) chain_i (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .shift_din(cfg_din),
    .image(image), .done(done_w)
  );

  assign mode_w   = cell_mode_e'(image[MODE_LSB +: 2]);
  assign fx_src_w = image[FX_BIT];
  assign fy_src_w = image[FY_BIT];

  lutcell_lut_core #(.EXT_N(EXT_N), .LUT_AW(LUT_AW), .SEL_W(SEL_W), .PINNED(2)) core_i (
    .table_bits(image[LUT_N-1:0]),
    .mode(mode_w),
    .s_sel(image[SSEL_LSB +: LUT_AW*SEL_W]),
    .t_sel(image[TSEL_LSB +: HALF_AW*SEL_W]),
    .ext(ext_in), .qa(qx_w), .qb(qy_w),
    .f_raw(f_raw), .g_raw(g_raw), .whole_w(whole_w)
  );

  lutcell_ff_pair regs_i (
    .clk(clk), .rst_n(rst_n), .run(done_w),
    .f_in(f_out), .g_in(g_out),
    .x_from_g(fx_src_w), .y_from_g(fy_src_w),
    .qx(qx_w), .qy(qy_w)
  );

  assign f_out    = done_w & f_raw;
  assign g_out    = done_w & g_raw;
  assign qx_out   = qx_w;
  assign qy_out   = qy_w;
  assign cfg_done = done_w;
endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_done,
  input logic f,
  input logic g,
  input logic qx,
  input logic qy,
  input logic fx_src,
  input logic fy_src,
  input logic whole_w
);
  // R1
  outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (!f && !g && !qx && !qy));

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  // R2
  done_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_en));

  // R4
  whole_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && whole_w) |-> (f == g));

  // R8
  x_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> (qx == $past(fx_src ? g : f)));

  // R8
  y_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> (qy == $past(fy_src ? g : f)));
endmodule

bind lutcell_top lutcell_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_done(cfg_done),
  .f(f_out), .g(g_out), .qx(qx_out), .qy(qy_out),
  .fx_src(fx_src_w), .fy_src(fy_src_w), .whole_w(whole_w)
);

// File: tb/lutcell_top_tb_top.sv
module lutcell_top_tb_top;
  localparam int CL = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [4:0] ext_in = '0;
  logic f_out, g_out, qx_out, qy_out, cfg_done;

  int checks = 0;
  int errors = 0;
  logic mx = 1'b0, my = 1'b0;

  always #2 clk = ~clk;

  lutcell_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .ext_in(ext_in), .f_out(f_out), .g_out(g_out),
    .qx_out(qx_out), .qy_out(qy_out), .cfg_done(cfg_done)
  );

  function automatic logic var3(input logic [2:0] sel, input logic pinned,
                                input logic [4:0] e, input logic a, input logic b);
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: return e[sel];
      3'd5: return pinned ? 1'b0 : a;
      3'd6: return pinned ? 1'b0 : b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CL-1:0] mk(input logic [31:0] lut, input logic [1:0] mode,
                                       input logic [14:0] s, input logic [11:0] t,
                                       input logic fx, input logic fy);
    return {fy, fx, t, s, mode, lut};
  endfunction

  function automatic logic [1:0] exp_fg(input logic [CL-1:0] c, input logic [4:0] e,
                                        input logic a, input logic b);
    logic [4:0] sa;
    logic [3:0] ta;
    logic lo, hi, wh, m;
    for (int k = 0; k < 5; k++) sa[k] = var3(c[34+3*k +: 3], k < 2, e, a, b);
    for (int k = 0; k < 4; k++) ta[k] = var3(c[49+3*k +: 3], k < 2, e, a, b);
    wh = c[sa];
    lo = c[{1'b0, sa[3:0]}];
    hi = c[{1'b1, ta}];
    m  = sa[4] ? hi : lo;
    case (c[33:32])
      2'd1: return {lo, hi};
      2'd2: return {m, m};
      default: return {wh, wh};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_in = 5'h1f;
    #1;
    check("R9 qx cleared", qx_out, 0);
    check("R9 qy cleared", qy_out, 0);
    check("R2 done low after reset", cfg_done, 0);
    check("R1 f low before config", f_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mx = 1'b0;
    my = 1'b0;
  endtask

  task automatic load(input logic [CL-1:0] c, input int gap_at);
    for (int i = CL - 1; i >= 0; i--) begin
      if (i == gap_at) begin
        cfg_en = 1'b0;
        repeat (3) @(negedge clk);
      end
      if (i == 0) check("R2 done low before last bit", cfg_done, 0);
      if (i == 20) begin
        ext_in = 5'h1f;
        #1;
        check("R1 outputs low mid-load", {f_out, g_out, qx_out, qy_out}, 0);
      end
      cfg_en = 1'b1;
      cfg_din = c[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    check("R2 done after full count", cfg_done, 1);
    check("R8 flops still clear at done", {qx_out, qy_out}, 0);
  endtask

  task automatic run_cycle(input logic [CL-1:0] c, input logic [4:0] e, input string tag);
    logic [1:0] fg;
    logic nx, ny;
    ext_in = e;
    #1;
    fg = exp_fg(c, e, mx, my);
    check({tag, " F"}, f_out, fg[1]);
    check({tag, " G"}, g_out, fg[0]);
    check("R8 qx", qx_out, mx);
    check("R8 qy", qy_out, my);
    nx = c[61] ? fg[0] : fg[1];
    ny = c[62] ? fg[0] : fg[1];
    @(posedge clk);
    mx = nx;
    my = ny;
    @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd1: return "R5";
      2'd2: return "R6";
      2'd3: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic scenario(input logic [CL-1:0] c, input int gap_at, input int n, input string tag);
    do_reset();
    load(c, gap_at);
    for (int j = 0; j < n; j++) run_cycle(c, 5'($urandom), tag);
  endtask

  initial begin
    logic [CL-1:0] c;
    void'($urandom(32'h1a2b3c4d));
    // R3 R4 R11: whole table, S_k = ext k; flip-flops take F and G
    c = mk(32'hcafe_8137, 2'd0, {3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 12'h000, 1'b0, 1'b1);
    scenario(c, 30, 24, "R3 R4 R11");
    // R2: gap near the end of the chain
    c = mk(32'h0f0f_3c3c, 2'd0, {3'd6, 3'd5, 3'd2, 3'd1, 3'd0}, 12'h000, 1'b1, 1'b0);
    scenario(c, 1, 24, "R2 R4 R7");
    // R5 R7: split; S0 = code 5 (pinned -> 0), S2 = qx, S3 = qy, T3 = 7
    c = mk(32'h9d5a_61e4, 2'd1, {3'd0, 3'd6, 3'd5, 3'd2, 3'd5},
           {3'd7, 3'd5, 3'd6, 3'd4}, 1'b0, 1'b1);
    scenario(c, -1, 30, "R5 R7");
    // R6: merged, select = flip-flop Y
    c = mk(32'h7310_ac4b, 2'd2, {3'd6, 3'd5, 3'd4, 3'd1, 3'd0},
           {3'd5, 3'd2, 3'd3, 3'd2}, 1'b1, 1'b0);
    scenario(c, -1, 30, "R6");
    // R10: mode 3
    c = mk(32'h5ee1_0b77, 2'd3, {3'd5, 3'd6, 3'd3, 3'd4, 3'd2}, 12'h000, 1'b0, 1'b1);
    scenario(c, -1, 24, "R10");
    for (int r = 0; r < 10; r++) begin
      c = {31'($urandom), 32'($urandom)};
      scenario(c, -1, 40, mode_tag(c[33:32]));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule